// File: doc/BRIEF.md
# Processor Status Word Register with Masked Write

This block keeps the status word of a processor core. Four condition flags (negative, zero, carry, overflow) occupy the top bits of the word. The remaining bits form a control word whose lowest five bits select the operating mode. Software-style updates arrive as a value paired with a per-bit mask. Arithmetic results arrive separately, as a set of per-flag enables and values from the ALU.

A read port returns the assembled word combinationally from the stored state. A masked write that alters the mode field raises a pulse one clock wide, together with the new mode. The surrounding core uses that pulse to swap its register banks. This block only signals that a swap is needed.

Top module: `status_word_reg`

## Requirements
- R1: After reset the read word is 0x0000_0013: all four flags are clear, the mode field (bits 4..0) holds 0x13, every other bit is 0, and mode_chg is low.
- R2: The read word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27..0 come from the stored control word.
- R3: A write whose mask has any of bits 31..28 set loads all four flags from wr_data[31:28] at the next clock edge. This includes flags whose own mask bit is clear.
- R4: On a write, each control bit 27..0 takes the wr_data bit where the mask bit is 1 and keeps its stored value where it is 0. Without wr_en the control word does not change.
- R5: A write that changes the stored mode field (bits 4..0) sets mode_chg for exactly the one clock cycle after the accepting edge. During that cycle mode_new equals the mode now stored. Back-to-back changing writes give one pulse per write.
- R6: A write that leaves the mode field unchanged raises no pulse. This covers a mask with no bits in 4..0, and a masked value equal to the stored mode.
- R7: alu_flag_en bit 3 selects N, bit 2 Z, bit 1 C and bit 0 V. When no flag write occurs, only the enabled flags take the matching alu_flag_val bit, and the others hold.
- R8: In a cycle where a write hits the flags (R3), the ALU flag inputs are ignored entirely. A write whose mask touches no flag bit does not block the ALU flag load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Masked write strobe |
| wr_data | input | 32 | Value to write |
| wr_mask | input | 32 | Per-bit write mask |
| alu_flag_en | input | 4 | Per-flag load enable from the ALU {N,Z,C,V} |
| alu_flag_val | input | 4 | Flag values from the ALU {N,Z,C,V} |
| rd_word | output | 32 | Assembled status word |
| mode_chg | output | 1 | One-cycle mode-change request |
| mode_new | output | 5 | Mode value that goes with mode_chg |

## Verification
The hardest case to reach is the collision between the two flag sources. A masked write that touches only one flag bit arrives in the same cycle as an ALU load that enables every flag with the opposite values. Only the write may win, so the stimulus drives exactly that pair. It also drives the reverse case: a control-only write alongside an ALU load, where the ALU result must land.

Mode events get the same kind of stimulus. A partial mode mask flips a single mode bit. Two changing writes are issued back to back. Writes that re-store the current mode must stay silent.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int FLAG_N = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;
endpackage

// File: rtl/sr_flag_bank.sv
module sr_flag_bank
   import sr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hit,
   input  logic [FLAG_N-1:0]   wr_flags,
   input  logic [FLAG_N-1:0]   alu_en,
   input  logic [FLAG_N-1:0]   alu_val,
   output flags_t              flags_q
);
   logic [FLAG_N-1:0] bits_q;

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q[g] <= 1'b0;
         end else if (wr_hit) begin
            bits_q[g] <= wr_flags[g];
         end else if (alu_en[g]) begin
            bits_q[g] <= alu_val[g];
         end
      end
   end

   assign flags_q = flags_t'(bits_q);

   // R3 / R8: a write to the flags overrides the ALU load
   a_r3_flag_write : assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (bits_q == $past(wr_flags)));

   // R7: without a write or an enable, the flags hold
   a_r7_flag_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && alu_en == '0) |=> $stable(bits_q));
endmodule

// File: rtl/sr_ctrl_word.sv
module sr_ctrl_word #(
   parameter int                CTRL_W   = 28,
   parameter int                MODE_W   = 5,
   parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_val,
   input  logic [CTRL_W-1:0] wr_msk,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam logic [CTRL_W-1:0] RST_WORD = CTRL_W'(RST_MODE);

   for (genvar g = 0; g < CTRL_W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[g] <= RST_WORD[g];
         end else if (wr_en && wr_msk[g]) begin
            ctrl_q[g] <= wr_val[g];
         end
      end
   end

   // R4: control word holds without a write
   a_r4_ctrl_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl_q));

   // R4: unmasked bits survive a write
   a_r4_unmasked_keep : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((ctrl_q & ~$past(wr_msk)) == ($past(ctrl_q) & ~$past(wr_msk))));
endmodule

// File: rtl/sr_mode_event.sv
module sr_mode_event #(
   parameter int MODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic [MODE_W-1:0] wr_mmask,
   output logic              chg_q,
   output logic [MODE_W-1:0] mode_q
);
   logic [MODE_W-1:0] diff;
   logic [MODE_W-1:0] next_mode;
   logic              change;

   always_comb begin
      diff      = (cur_mode ^ wr_mode) & wr_mmask;
      next_mode = (cur_mode & ~wr_mmask) | (wr_mode & wr_mmask);
      change    = wr_en && (diff != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chg_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         chg_q <= change;
         if (change) begin
            mode_q <= next_mode;
         end
      end
   end

   // R5: a pulse only follows an accepted write
   a_r5_after_write : assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> $past(wr_en));

   // R6: a write that leaves the mode alone is silent
   a_r6_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((cur_mode ^ wr_mode) & wr_mmask) == '0) |=> !chg_q);
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
   import sr_pkg::*;
#(
   parameter int                WORD_W   = 32,
   parameter int                MODE_W   = 5,
   parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] wr_mask,
   input  logic [3:0]        alu_flag_en,
   input  logic [3:0]        alu_flag_val,
   output logic [WORD_W-1:0] rd_word,
   output logic              mode_chg,
   output logic [MODE_W-1:0] mode_new
);
   localparam int CTRL_W = WORD_W - FLAG_N;

   if (FLAG_N != 4) begin : g_chk_flags
      $error("status_word_reg: exactly four flags are supported");
   end
   if (MODE_W < 1 || MODE_W >= CTRL_W) begin : g_chk_mode
      $error("status_word_reg: mode field must fit below the flags");
   end

   flags_t            flags_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              flag_hit;

   assign flag_hit = wr_en && (wr_mask[WORD_W-1 -: FLAG_N] != '0);

   sr_flag_bank i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (flag_hit),
      .wr_flags (wr_data[WORD_W-1 -: FLAG_N]),
      .alu_en   (alu_flag_en),
      .alu_val  (alu_flag_val),
      .flags_q  (flags_q)
   );

   sr_ctrl_word #(
      .CTRL_W   (CTRL_W),
      .MODE_W   (MODE_W),
      .RST_MODE (RST_MODE)
   ) i_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_val (wr_data[CTRL_W-1:0]),
      .wr_msk (wr_mask[CTRL_W-1:0]),
      .ctrl_q (ctrl_q)
   );

   sr_mode_event #(
      .MODE_W (MODE_W)
   ) i_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .cur_mode (ctrl_q[MODE_W-1:0]),
      .wr_mode  (wr_data[MODE_W-1:0]),
      .wr_mmask (wr_mask[MODE_W-1:0]),
      .chg_q    (mode_chg),
      .mode_q   (mode_new)
   );

   assign rd_word = {flags_q, ctrl_q};

   // R5: the reported mode matches what a read shows during the pulse
   a_r5_mode_match : assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> (rd_word[MODE_W-1:0] == mode_new));

   // R5: a pulse without a new write lasts one cycle
   a_r5_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && !wr_en) |=> !mode_chg);
endmodule

// File: tb/test_status_word_reg.sv
`timescale 1ns/1ps
module test_status_word_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] wr_mask = '0;
   logic [3:0]  alu_flag_en = '0;
   logic [3:0]  alu_flag_val = '0;
   logic [31:0] rd_word;
   logic        mode_chg;
   logic [4:0]  mode_new;

   always #4 clk = ~clk;

   status_word_reg i_status_word_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .wr_mask      (wr_mask),
      .alu_flag_en  (alu_flag_en),
      .alu_flag_val (alu_flag_val),
      .rd_word      (rd_word),
      .mode_chg     (mode_chg),
      .mode_new     (mode_new)
   );

   typedef struct {
      logic [31:0] word;
      logic        chg;
      logic [4:0]  mode;
      string       tag;
   } exp_t;

   exp_t   q[$];
   int     errors = 0;
   int     checks = 0;
   bit     done = 1'b0;
   logic [3:0]  m_flags = 4'h0;
   logic [27:0] m_ctrl  = 28'h13;

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (rd_word !== e.word) begin
            errors++;
            $display("FAIL %s rd_word actual=%h expected=%h", e.tag, rd_word, e.word);
         end
         checks++;
         if (mode_chg !== e.chg) begin
            errors++;
            $display("FAIL %s mode_chg actual=%b expected=%b", e.tag, mode_chg, e.chg);
         end
         if (e.chg) begin
            checks++;
            if (mode_new !== e.mode) begin
               errors++;
               $display("FAIL %s mode_new actual=%h expected=%h", e.tag, mode_new, e.mode);
            end
         end
      end
   end

   task automatic step(input logic we, input logic [31:0] d, input logic [31:0] m,
                       input logic [3:0] fe, input logic [3:0] fv, input string tag);
      exp_t        e;
      logic [4:0]  old_mode;
      logic [27:0] nc;
      @(negedge clk);
      wr_en = we; wr_data = d; wr_mask = m; alu_flag_en = fe; alu_flag_val = fv;
      old_mode = m_ctrl[4:0];
      nc = m_ctrl;
      if (we && (m[31:28] != 4'h0)) begin
         m_flags = d[31:28];
      end else begin
         for (int i = 0; i < 4; i++) if (fe[i]) m_flags[i] = fv[i];
      end
      if (we) nc = (m_ctrl & ~m[27:0]) | (d[27:0] & m[27:0]);
      m_ctrl = nc;
      @(posedge clk);
      e.word = {m_flags, m_ctrl};
      e.chg  = we && (m_ctrl[4:0] != old_mode);
      e.mode = m_ctrl[4:0];
      e.tag  = tag;
      q.push_back(e);
   endtask

   initial begin
      exp_t e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      e.word = 32'h0000_0013; e.chg = 1'b0; e.mode = 5'h0; e.tag = "R1";
      q.push_back(e);
      step(1'b0, 32'h0, 32'h0, 4'h0, 4'h0, "R1");
      step(1'b1, 32'h0ABC_DEF3, 32'h0FFF_FFE0, 4'h0, 4'h0, "R4");
      step(1'b1, 32'h0000_0000, 32'h00F0_0F00, 4'h0, 4'h0, "R4");
      step(1'b1, 32'hA000_0000, 32'h1000_0000, 4'h0, 4'h0, "R3");
      step(1'b1, 32'h5FFF_FFFF, 32'h8000_0000, 4'h0, 4'h0, "R2");
      step(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0, 4'h0, "R4");
      step(1'b1, 32'h0000_001F, 32'h0000_001F, 4'h0, 4'h0, "R5");
      step(1'b0, 32'h0, 32'h0, 4'h0, 4'h0, "R5");
      step(1'b1, 32'h0000_0000, 32'h0000_0001, 4'h0, 4'h0, "R5");
      step(1'b1, 32'h0000_0010, 32'h0000_001F, 4'h0, 4'h0, "R5");
      step(1'b1, 32'h0000_0013, 32'h0000_001F, 4'h0, 4'h0, "R5");
      step(1'b1, 32'h0000_0013, 32'h0000_001F, 4'h0, 4'h0, "R6");
      step(1'b1, 32'hFFFF_FFE0, 32'h0FFF_FFE0, 4'h0, 4'h0, "R6");
      step(1'b1, 32'h0000_0000, 32'hF000_0000, 4'h0, 4'h0, "R3");
      step(1'b0, 32'h0, 32'h0, 4'b0101, 4'b1111, "R7");
      step(1'b0, 32'h0, 32'h0, 4'b1010, 4'b1000, "R7");
      step(1'b1, 32'h0000_0000, 32'h2000_0000, 4'b1111, 4'b1111, "R8");
      step(1'b1, 32'h0000_0100, 32'h0000_0100, 4'b1000, 4'b1111, "R8");
      step(1'b1, 32'hF000_0000, 32'h0100_0000, 4'b1111, 4'b0000, "R8");
      step(1'b0, 32'h0, 32'h0, 4'h0, 4'h0, "R2");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule